// File: doc/BRIEF.md
# Keyboard-to-LCD Mode Sequencer

This block is the top-level input/output mode machine that sits between a keyboard receiver, a character display writer and a system controller. Keyboard characters arrive as ASCII bytes with a one-cycle valid strobe. A 4-bit switch setting selects how they travel. In direct mode every keystroke is echoed to the display. In buffered mode keystrokes are collected and shown only once the Enter key is pressed. In functional mode keystrokes, including the leading opcode characters, are queued for the system controller, and result characters from the logic units are sent to the display.

All three modes share a single character queue. Display writes leave through a one-entry output slot that uses a request/ready handshake. The current mode is always visible on a status output. A sticky flag records any keystroke that was lost because the queue was full.

Top module: `kbd_lcd_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `mode_status` = 0 (reset), `lcd_req` = 0, `overflow` = 0 and `sc_avail` = 0.
- R2: One edge after reset is released, `mode_status` is 1 (idle). From idle, the next edge enters a mode chosen by `dip_sel`: 4'b0001 gives direct (status 2), 4'b0010 gives buffered (status 3), 4'b0100 gives functional (status 4). Any other value leaves the block in idle.
- R3: In a mode state, if `dip_sel` differs from that mode's code, the next edge returns the block to idle. Every queued character is then discarded.
- R4: In direct mode, every keyboard character is written to the display in arrival order.
- R5: In buffered mode, characters are queued and nothing reaches the display until 8'h0D (Enter) arrives. The Enter byte is not queued. The queue is then drained to the display in order until it is empty.
- R6: In functional mode, keyboard characters are queued. The queue head appears on `sc_char` with `sc_avail` high, and each cycle with `sc_take` high removes one character in order.
- R7: In functional mode, a result character is accepted at an edge where `res_valid` and `res_ready` are both high, and it is then written to the display in order. `res_ready` is low in every other mode and whenever a display write is pending.
- R8: A display character is transferred at an edge where `lcd_req` and `lcd_ready` are both high. Until that edge, `lcd_req` stays high and `lcd_char` does not change. Exactly one character moves per handshake.
- R9: The queue holds `DEPTH` (64) characters. A keystroke that arrives while the queue is full is dropped and sets `overflow`, which stays high until reset.
- R10: Keyboard characters that arrive in the reset or idle state are ignored and never reach the display.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high global reset |
| dip_sel | input | 4 | Mode selection switches |
| kb_valid | input | 1 | Keyboard character strobe |
| kb_char | input | 8 | Keyboard ASCII character |
| lcd_ready | input | 1 | Display writer can take a character |
| lcd_req | output | 1 | Display write request |
| lcd_char | output | 8 | Character to display |
| sc_avail | output | 1 | Queue head valid for system controller |
| sc_char | output | 8 | Queue head character |
| sc_take | input | 1 | System controller removes queue head |
| res_valid | input | 1 | Result character valid from logic units |
| res_char | input | 8 | Result character |
| res_ready | output | 1 | Result character can be accepted |
| mode_status | output | 3 | Current mode: 0 reset, 1 idle, 2 direct, 3 buffered, 4 functional |
| overflow | output | 1 | Sticky lost-keystroke flag |

## Verification
The assertions take for granted that the display writer holds `lcd_ready` steady between clock edges. They also assume the system controller raises `sc_take` only while `sc_avail` is high, and that `res_valid` and `res_char` change only between edges. The stimulus drives every input on the falling edge and pulses `sc_take` only after it has seen `sc_avail` high. The display stub switches between constant readiness and alternating readiness, which exercises both back-to-back and stalled transfers.

// File: rtl/kls_pkg.sv
package kls_pkg;
  typedef enum logic [2:0] {
    ST_RST    = 3'd0,
    ST_IDLE   = 3'd1,
    ST_DIRECT = 3'd2,
    ST_BUF    = 3'd3,
    ST_FUNC   = 3'd4
  } mode_e;

  localparam logic [3:0] SEL_DIRECT = 4'b0001;
  localparam logic [3:0] SEL_BUF    = 4'b0010;
  localparam logic [3:0] SEL_FUNC   = 4'b0100;
  localparam int         CHAR_W     = 8;
  localparam logic [CHAR_W-1:0] KEY_ENTER = 8'h0D;
endpackage

// File: rtl/kls_char_fifo.sv
module kls_char_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    fill,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;

  // storage has no reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      if (pop)  rd_ptr <= rd_ptr + AW'(1);
      fill <= fill + CW'(push) - CW'(pop);
    end
  end

  assign rdata = mem[rd_ptr];
  assign empty = (fill == '0);
  assign full  = (fill == CW'(DEPTH));
endmodule

// File: rtl/kls_mode_fsm.sv
module kls_mode_fsm
  import kls_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] dip_sel,
  input  logic       enter_hit,
  input  logic       queue_empty,
  input  logic       queue_push,
  output mode_e      state,
  output logic       released
);
  logic stay;

  always_comb begin
    unique case (state)
      ST_DIRECT: stay = (dip_sel == SEL_DIRECT);
      ST_BUF:    stay = (dip_sel == SEL_BUF);
      ST_FUNC:   stay = (dip_sel == SEL_FUNC);
      default:   stay = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_RST;
    end else begin
      unique case (state)
        ST_RST:  state <= ST_IDLE;
        ST_IDLE: begin
          unique case (dip_sel)
            SEL_DIRECT: state <= ST_DIRECT;
            SEL_BUF:    state <= ST_BUF;
            SEL_FUNC:   state <= ST_FUNC;
            default:    state <= ST_IDLE;
          endcase
        end
        default: if (!stay) state <= ST_IDLE;
      endcase
    end
  end

  // release window for buffered mode: opens on Enter, closes once drained
  always_ff @(posedge clk) begin
    if (rst || state != ST_BUF || !stay) begin
      released <= 1'b0;
    end else if (enter_hit) begin
      released <= 1'b1;
    end else if (released && queue_empty && !queue_push) begin
      released <= 1'b0;
    end
  end
endmodule

// File: rtl/kls_lcd_slot.sv
module kls_lcd_slot #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] load_char,
  input  logic             lcd_ready,
  output logic             lcd_req,
  output logic [WIDTH-1:0] lcd_char
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lcd_req  <= 1'b0;
      lcd_char <= '0;
    end else if (load) begin
      lcd_req  <= 1'b1;
      lcd_char <= load_char;
    end else if (lcd_ready) begin
      lcd_req  <= 1'b0;
    end
  end
endmodule

// File: rtl/kbd_lcd_sequencer.sv
module kbd_lcd_sequencer
  import kls_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = CHAR_W,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       dip_sel,
  input  logic             kb_valid,
  input  logic [WIDTH-1:0] kb_char,
  input  logic             lcd_ready,
  output logic             lcd_req,
  output logic [WIDTH-1:0] lcd_char,
  output logic             sc_avail,
  output logic [WIDTH-1:0] sc_char,
  input  logic             sc_take,
  input  logic             res_valid,
  input  logic [WIDTH-1:0] res_char,
  output logic             res_ready,
  output logic [2:0]       mode_status,
  output logic             overflow
);
  mode_e            state;
  logic             released;
  logic [CW-1:0]    fill;
  logic             empty, full;
  logic [WIDTH-1:0] head;
  logic             in_mode, is_enter, kb_store, push, drop;
  logic             drain_en, slot_free, pop_lcd, pop_sc, pop;
  logic             res_load, slot_load;
  logic [WIDTH-1:0] slot_char;

  assign in_mode   = (state == ST_DIRECT) || (state == ST_BUF) || (state == ST_FUNC);
  assign is_enter  = (kb_char == WIDTH'(KEY_ENTER));
  assign kb_store  = kb_valid && in_mode && !((state == ST_BUF) && is_enter);
  assign push      = kb_store && !full;
  assign drop      = kb_store && full;

  assign drain_en  = (state == ST_DIRECT) || ((state == ST_BUF) && released);
  assign slot_free = !lcd_req || lcd_ready;
  assign pop_lcd   = drain_en && !empty && slot_free;
  assign pop_sc    = (state == ST_FUNC) && sc_take && !empty;
  assign pop       = pop_lcd || pop_sc;

  assign res_ready = (state == ST_FUNC) && !lcd_req;
  assign res_load  = res_valid && res_ready;
  assign slot_load = pop_lcd || res_load;
  assign slot_char = pop_lcd ? head : res_char;

  kls_mode_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .dip_sel     (dip_sel),
    .enter_hit   (kb_valid && (state == ST_BUF) && is_enter),
    .queue_empty (empty),
    .queue_push  (push),
    .state       (state),
    .released    (released)
  );

  kls_char_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .flush (!in_mode),
    .push  (push),
    .wdata (kb_char),
    .pop   (pop),
    .rdata (head),
    .fill  (fill),
    .empty (empty),
    .full  (full)
  );

  kls_lcd_slot #(.WIDTH(WIDTH)) u_slot (
    .clk       (clk),
    .rst       (rst),
    .load      (slot_load),
    .load_char (slot_char),
    .lcd_ready (lcd_ready),
    .lcd_req   (lcd_req),
    .lcd_char  (lcd_char)
  );

  always_ff @(posedge clk) begin
    if (rst)       overflow <= 1'b0;
    else if (drop) overflow <= 1'b1;
  end

  assign sc_avail    = (state == ST_FUNC) && !empty;
  assign sc_char     = head;
  assign mode_status = state;
endmodule

// File: rtl/kls_checker.sv
module kls_checker #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       dip_sel,
  input logic             kb_valid,
  input logic [WIDTH-1:0] kb_char,
  input logic             lcd_ready,
  input logic             lcd_req,
  input logic [WIDTH-1:0] lcd_char,
  input logic             sc_avail,
  input logic             res_ready,
  input logic [2:0]       mode_status,
  input logic             overflow,
  input logic [CW-1:0]    fill
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (mode_status == 3'd0 && !lcd_req && !overflow && !sc_avail));

  assert_leave_reset_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_status == 3'd0) |=> (mode_status == 3'd1));

  assert_switch_exit_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_status == 3'd3 && dip_sel != 4'b0010) |=> (mode_status == 3'd1));

  assert_enter_not_stored_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_status == 3'd3 && dip_sel == 4'b0010 && kb_valid && kb_char == 8'h0D)
      |=> (fill <= $past(fill)));

  assert_sc_only_functional_R6: assert property (@(posedge clk) disable iff (rst)
    sc_avail |-> (mode_status == 3'd4));

  assert_res_ready_gate_R7: assert property (@(posedge clk) disable iff (rst)
    res_ready |-> (mode_status == 3'd4 && !lcd_req));

  assert_lcd_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (lcd_req && !lcd_ready) |=> (lcd_req && $stable(lcd_char)));

  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  assert_fill_bound_R9: assert property (@(posedge clk) disable iff (rst)
    fill <= CW'(DEPTH));

  assert_idle_empty_R10: assert property (@(posedge clk) disable iff (rst)
    (mode_status == 3'd1) |=> (fill == '0 || mode_status != 3'd1));
endmodule

bind kbd_lcd_sequencer kls_checker #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .dip_sel     (dip_sel),
  .kb_valid    (kb_valid),
  .kb_char     (kb_char),
  .lcd_ready   (lcd_ready),
  .lcd_req     (lcd_req),
  .lcd_char    (lcd_char),
  .sc_avail    (sc_avail),
  .res_ready   (res_ready),
  .mode_status (mode_status),
  .overflow    (overflow),
  .fill        (fill)
);

// File: tb/kbd_lcd_sequencer_test.sv
`timescale 1ns/1ps
module kbd_lcd_sequencer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] dip_sel = 4'd0;
  logic       kb_valid = 1'b0;
  logic [7:0] kb_char = 8'd0;
  logic       lcd_ready = 1'b1;
  logic       lcd_req;
  logic [7:0] lcd_char;
  logic       sc_avail;
  logic [7:0] sc_char;
  logic       sc_take = 1'b0;
  logic       res_valid = 1'b0;
  logic [7:0] res_char = 8'd0;
  logic       res_ready;
  logic [2:0] mode_status;
  logic       overflow;

  int checks = 0;
  int errors = 0;
  logic [7:0] got [0:255];
  int ngot = 0;
  bit rdy_alt = 1'b0;

  always #2 clk = ~clk;

  kbd_lcd_sequencer uut (
    .clk(clk), .rst(rst), .dip_sel(dip_sel),
    .kb_valid(kb_valid), .kb_char(kb_char),
    .lcd_ready(lcd_ready), .lcd_req(lcd_req), .lcd_char(lcd_char),
    .sc_avail(sc_avail), .sc_char(sc_char), .sc_take(sc_take),
    .res_valid(res_valid), .res_char(res_char), .res_ready(res_ready),
    .mode_status(mode_status), .overflow(overflow)
  );

  // display writer stub: picks readiness, records each completed handshake
  always @(negedge clk) begin
    lcd_ready = rdy_alt ? ~lcd_ready : 1'b1;
    if (lcd_req && lcd_ready && ngot < 256) begin
      got[ngot] = lcd_char;
      ngot = ngot + 1;
    end
  end

  task automatic chk_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] d);
    @(negedge clk);
    rst = 1'b1;
    dip_sel = d;
    repeat (3) @(negedge clk);
    chk_eq("R1 status", mode_status, 0);
    chk_eq("R1 lcd_req", lcd_req, 0);
    chk_eq("R1 overflow", overflow, 0);
    chk_eq("R1 sc_avail", sc_avail, 0);
    rst = 1'b0;
    @(negedge clk);
    chk_eq("R2 idle after reset", mode_status, 1);
    @(negedge clk);
    ngot = 0;
  endtask

  task automatic kb_send(input logic [7:0] c);
    kb_valid = 1'b1;
    kb_char = c;
    @(negedge clk);
    kb_valid = 1'b0;
  endtask

  function automatic int mode_for(input int d);
    if (d == 1) return 2;
    if (d == 2) return 3;
    if (d == 4) return 4;
    return 1;
  endfunction

  initial begin
    // R2: every switch value
    for (int d = 0; d < 16; d++) begin
      do_reset(4'(d));
      chk_eq($sformatf("R2 mode for switch %0d", d), mode_status, mode_for(d));
      @(negedge clk);
      chk_eq("R2 mode held", mode_status, mode_for(d));
    end

    // R10: keys in reset and idle ignored
    @(negedge clk); rst = 1'b1; dip_sel = 4'd0;
    kb_send(8'h41); kb_send(8'h42);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    kb_send(8'h43); kb_send(8'h44);
    dip_sel = 4'b0001;
    repeat (20) @(negedge clk);
    chk_eq("R10 direct entered", mode_status, 2);
    chk_eq("R10 nothing displayed", ngot, 0);

    // R4/R8: direct echo under stalled handshakes
    rdy_alt = 1'b1;
    ngot = 0;
    for (int i = 0; i < 12; i++) kb_send(8'h41 + 8'(i));
    repeat (60) @(negedge clk);
    chk_eq("R4 direct count", ngot, 12);
    for (int i = 0; i < 12; i++) chk_eq("R8 R4 direct order", got[i], 8'h41 + i);
    chk_eq("R7 res_ready low in direct", res_ready, 0);

    // R5: buffered release on Enter
    rdy_alt = 1'b0;
    do_reset(4'b0010);
    for (int i = 0; i < 5; i++) kb_send(8'h61 + 8'(i));
    repeat (20) @(negedge clk);
    chk_eq("R5 held before Enter", ngot, 0);
    kb_send(8'h0D);
    repeat (30) @(negedge clk);
    chk_eq("R5 released count", ngot, 5);
    for (int i = 0; i < 5; i++) chk_eq("R5 released order", got[i], 8'h61 + i);
    // second round reuses the queue
    ngot = 0;
    kb_send(8'h31); kb_send(8'h32);
    repeat (10) @(negedge clk);
    chk_eq("R5 second hold", ngot, 0);
    kb_send(8'h0D);
    repeat (10) @(negedge clk);
    chk_eq("R5 second count", ngot, 2);
    chk_eq("R5 second char", got[1], 8'h32);

    // R9: fill to depth, overflow, sticky, reset clears
    do_reset(4'b0010);
    for (int i = 0; i < 64; i++) kb_send(8'h20 + 8'(i));
    chk_eq("R9 no overflow at depth", overflow, 0);
    for (int i = 0; i < 6; i++) kb_send(8'h70);
    chk_eq("R9 overflow set", overflow, 1);
    chk_eq("R5 nothing shown while full", ngot, 0);
    rdy_alt = 1'b1;
    kb_send(8'h0D);
    repeat (300) @(negedge clk);
    chk_eq("R9 drained count", ngot, 64);
    for (int i = 0; i < 64; i++) chk_eq("R9 drained order", got[i], 8'h20 + i);
    chk_eq("R9 overflow sticky", overflow, 1);
    rdy_alt = 1'b0;
    do_reset(4'b0010);
    chk_eq("R9 overflow cleared", overflow, 0);

    // R3: switch change discards queue
    kb_send(8'h51); kb_send(8'h52); kb_send(8'h53);
    dip_sel = 4'd0;
    @(negedge clk);
    chk_eq("R3 back to idle", mode_status, 1);
    @(negedge clk);
    dip_sel = 4'b0010;
    @(negedge clk);
    chk_eq("R3 buffered again", mode_status, 3);
    kb_send(8'h0D);
    repeat (20) @(negedge clk);
    chk_eq("R3 queue discarded", ngot, 0);

    // R6/R7: functional path
    do_reset(4'b0100);
    chk_eq("R6 empty queue", sc_avail, 0);
    for (int i = 0; i < 6; i++) kb_send(8'h30 + 8'(i));
    chk_eq("R6 nothing to display", ngot, 0);
    for (int i = 0; i < 6; i++) begin
      chk_eq("R6 sc_avail", sc_avail, 1);
      chk_eq("R6 sc_char order", sc_char, 8'h30 + i);
      sc_take = 1'b1;
      @(negedge clk);
      sc_take = 1'b0;
    end
    chk_eq("R6 drained", sc_avail, 0);
    rdy_alt = 1'b1;
    for (int i = 0; i < 5; i++) begin
      res_valid = 1'b1;
      res_char = 8'h4B + 8'(i);
      while (!res_ready) @(negedge clk);
      @(negedge clk);
      res_valid = 1'b0;
    end
    repeat (20) @(negedge clk);
    chk_eq("R7 result count", ngot, 5);
    for (int i = 0; i < 5; i++) chk_eq("R7 result order", got[i], 8'h4B + i);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule